// File: doc/BRIEF.md
# Transmit Descriptor Fetch and Stream Engine

This block is a bus master that walks a chain of transmit descriptors held in host memory and plays the buffer each one names out as a byte stream toward a MAC. Software builds a chain of 32-byte descriptors and loads the 64-bit chain pointer through two 32-bit register writes. It then sets a poll bit in a control register. The engine reads the descriptor the pointer names. When the descriptor holds a frame, the engine reads the referenced buffer one 64-bit word at a time, emits its bytes with start and end markers, and writes the status word back with the empty flag set. It then follows the next-descriptor link. The chain ends when a descriptor is read whose empty flag is already set. The pointer is left on that descriptor, so a later poll resumes there once software has filled it.

Each descriptor has four 64-bit words. At byte offset 0 is the next link. At offset 8 is the status word: bit 31 is the empty flag, bits 30:24 are the fragment count, and bits 17:16 both set allow any buffer alignment. At offset 16 is the fragment word: length in bits 63:48 and byte address in bits 47:0. The word at offset 24 is not read. Memory is little-endian: the byte at address A is bits (A mod 8)*8+7 down to (A mod 8)*8 of the 64-bit word at A with its low three bits cleared.

Top module: `tx_desc_dma`

## Requirements
- R1: After reset the engine is idle: `mem_req` and `tx_valid` are low until a poll is requested.
- R2: A register write to offset 0x00 with bit 12 set starts a fetch at the chain pointer. The pointer's low half is written at offset 0x10 and its high half at 0x14. The low 5 pointer bits are ignored, so the first read goes to the pointer with its low 5 bits cleared.
- R3: The descriptor is read at pointer+0, then pointer+8. If bit 31 of the status word is set, the engine stops after that read, writes nothing, and keeps the pointer, so the next poll reads the same descriptor again.
- R4: For a non-empty descriptor, the engine emits exactly `length` bytes from ascending buffer addresses. `tx_sof` marks the first byte and `tx_eof` the last, and `tx_valid` is low in the cycle after an end byte is accepted.
- R5: When status bits 17:16 are both 1, the buffer starts at the exact byte address. Otherwise the address's low 3 bits are taken as zero.
- R6: After a frame's last byte, the engine writes the status word, with bit 31 set and all other bits unchanged, to pointer+8. It then loads the pointer from the next link and fetches that descriptor.
- R7: A descriptor with fragment length 0 or fragment count (status bits 30:24) 0 is written back as complete, as in R6, without any output byte.
- R8: A poll request made while the engine is busy is held and served once the chain has stopped at an empty descriptor.
- R9: Pointer register writes made while the engine is busy are ignored.
- R10: A memory request holds its address, direction and write data until `mem_ack`. An output byte holds its data and markers until `tx_ready`.
- R11: At most one transaction is open at a time: a memory request and an output byte are never offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address of the 64-bit word |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid with it |
| mem_rdata | input | 64 | Read data |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Sink takes the byte |
| tx_data | output | 8 | Output byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |

## Verification
Corrupt internal state shows up quickly at the ports. A wrong byte offset or stale word buffer gives wrong bytes within a frame's first eight bytes. A wrong remaining count moves the end marker or drops or adds bytes before the write-back. A bad pointer update makes the next read go to the wrong descriptor address, one request after the write-back. A lost held poll shows as a missing second read of the stopping descriptor. The bench uses a randomly stalling memory and sink, and compares every byte, marker, written word and observed read address with values it computes from its own memory image.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  localparam int DESC_EMPTY_BIT = 31;
  localparam int DESC_CNT_LSB   = 24;
  localparam int DESC_ALN_LO    = 16;
  localparam int DESC_ALN_HI    = 17;
  localparam int CTL_POLL_BIT   = 12;
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_PTR_LO = 8'h10;
  localparam logic [7:0] OFS_PTR_HI = 8'h14;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LINK, ST_STAT, ST_FRAG, ST_FETCH, ST_SEND, ST_DONE
  } tdma_state_e;
endpackage

// File: rtl/tdma_regs.sv
module tdma_regs import tdma_pkg::*; #(
  parameter int AW  = 64,
  parameter int RAW = 8,
  parameter int RDW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RAW-1:0] addr,
  input  logic [RDW-1:0] wdata,
  input  logic          idle,
  input  logic          take_poll,
  input  logic          adv,
  input  logic [AW-1:0] adv_ptr,
  output logic [AW-1:0] ptr,
  output logic          poll_pend
);
  logic hit_ctrl, hit_lo, hit_hi;

  assign hit_ctrl = we && (addr == RAW'(OFS_CTRL));
  assign hit_lo   = we && idle && (addr == RAW'(OFS_PTR_LO));
  assign hit_hi   = we && idle && (addr == RAW'(OFS_PTR_HI));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      poll_pend <= 1'b0;
    end else begin
      if (adv)         ptr <= adv_ptr;
      else if (hit_lo) ptr[RDW-1:0]    <= wdata;
      else if (hit_hi) ptr[AW-1:RDW]   <= wdata[AW-RDW-1:0];
      if (hit_ctrl && wdata[CTL_POLL_BIT]) poll_pend <= 1'b1;
      else if (take_poll)                  poll_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/tdma_lane.sv
module tdma_lane #(
  parameter int DW = 64,
  localparam int SW = $clog2(DW / 8)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] sel,
  output logic [7:0]    dout
);
  logic [DW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst)       word_q <= '0;
    else if (load) word_q <= din;
  end

  assign dout = 8'(word_q >> {sel, 3'b000});
endmodule

// File: rtl/tx_desc_dma.sv
module tx_desc_dma import tdma_pkg::*; #(
  parameter int AW  = 64,
  parameter int LW  = 16,
  parameter int CW  = 7,
  parameter int RAW = 8,
  parameter int RDW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [RDW-1:0] reg_wdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [63:0]    mem_wdata,
  input  logic           mem_ack,
  input  logic [63:0]    mem_rdata,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [7:0]     tx_data,
  output logic           tx_sof,
  output logic           tx_eof
);
  localparam int DW  = 64;
  localparam int FAW = DW - LW;
  localparam int SW  = $clog2(DW / 8);
  localparam logic [AW-1:0] DESC_MASK = ~AW'(31);
  localparam logic [AW-1:0] WORD_MASK = ~AW'(DW / 8 - 1);

  tdma_state_e   state_q;
  logic [AW-1:0] link_q, baddr_q, ptr, dptr;
  logic [DW-1:0] stat_q;
  logic [LW-1:0] remain_q;
  logic          first_q, poll_pend, take_poll, adv, lane_load;

  logic [LW-1:0]  f_len;
  logic [FAW-1:0] f_adr;
  logic           f_any, f_void;

  assign take_poll = (state_q == ST_IDLE) && poll_pend;
  assign adv       = (state_q == ST_DONE) && mem_ack;
  assign lane_load = (state_q == ST_FETCH) && mem_ack;
  assign dptr      = ptr & DESC_MASK;

  tdma_regs #(.AW(AW), .RAW(RAW), .RDW(RDW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .idle(state_q == ST_IDLE), .take_poll(take_poll), .adv(adv),
    .adv_ptr(link_q), .ptr(ptr), .poll_pend(poll_pend)
  );

  tdma_lane #(.DW(DW)) u_lane (
    .clk(clk), .rst(rst), .load(lane_load), .din(mem_rdata),
    .sel(baddr_q[SW-1:0]), .dout(tx_data)
  );

  assign f_len  = mem_rdata[DW-1 -: LW];
  assign f_adr  = mem_rdata[FAW-1:0];
  assign f_any  = &stat_q[DESC_ALN_HI:DESC_ALN_LO];
  assign f_void = (f_len == '0) || (stat_q[DESC_CNT_LSB +: CW] == '0);

  always_comb begin
    mem_req  = 1'b1;
    mem_we   = 1'b0;
    mem_addr = dptr;
    unique case (state_q)
      ST_LINK:  mem_addr = dptr;
      ST_STAT:  mem_addr = dptr | AW'(8);
      ST_FRAG:  mem_addr = dptr | AW'(16);
      ST_FETCH: mem_addr = baddr_q & WORD_MASK;
      ST_DONE: begin
        mem_addr = dptr | AW'(8);
        mem_we   = 1'b1;
      end
      default:  mem_req = 1'b0;
    endcase
  end

  assign mem_wdata = stat_q | (DW'(1) << DESC_EMPTY_BIT);
  assign tx_valid  = (state_q == ST_SEND);
  assign tx_sof    = tx_valid && first_q;
  assign tx_eof    = tx_valid && (remain_q == LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      link_q   <= '0;
      stat_q   <= '0;
      baddr_q  <= '0;
      remain_q <= '0;
      first_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (poll_pend) state_q <= ST_LINK;
        ST_LINK: if (mem_ack) begin
          link_q  <= mem_rdata[AW-1:0];
          state_q <= ST_STAT;
        end
        ST_STAT: if (mem_ack) begin
          stat_q  <= mem_rdata;
          state_q <= mem_rdata[DESC_EMPTY_BIT] ? ST_IDLE : ST_FRAG;
        end
        ST_FRAG: if (mem_ack) begin
          baddr_q  <= f_any ? AW'(f_adr) : (AW'(f_adr) & WORD_MASK);
          remain_q <= f_len;
          first_q  <= 1'b1;
          state_q  <= f_void ? ST_DONE : ST_FETCH;
        end
        ST_FETCH: if (mem_ack) state_q <= ST_SEND;
        ST_SEND: if (tx_ready) begin
          baddr_q  <= baddr_q + AW'(1);
          remain_q <= remain_q - LW'(1);
          first_q  <= 1'b0;
          if (remain_q == LW'(1))         state_q <= ST_DONE;
          else if (&baddr_q[SW-1:0])      state_q <= ST_FETCH;
        end
        ST_DONE: if (mem_ack) state_q <= ST_LINK;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_desc_dma_chk.sv
module tx_desc_dma_chk (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_we,
  input logic [63:0] mem_addr,
  input logic [63:0] mem_wdata,
  input logic        mem_ack,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_sof,
  input logic        tx_eof
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req && !tx_valid));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof)));

  // R11
  one_txn_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && tx_valid));

  // R6
  wb_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata[31] && (mem_addr[4:0] == 5'h08)));

  // R4
  eof_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_eof) |=> !tx_valid);
endmodule

bind tx_desc_dma tx_desc_dma_chk u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_sof(tx_sof), .tx_eof(tx_eof)
);

// File: tb/sim_tx_desc_dma.sv
`timescale 1ns/1ps
module sim_tx_desc_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [63:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        tx_valid, tx_ready = 1'b0, tx_sof, tx_eof;
  logic [7:0]  tx_data;

  logic [63:0] mem [0:255];
  logic [7:0]  cap_b[$];
  logic        cap_s[$], cap_e[$];
  logic [7:0]  exp_b[$];
  logic        exp_s[$], exp_e[$];
  logic [63:0] first_rd, watch_a, watch_b;
  logic        first_seen;
  int          hits_a, hits_b, n_chk = 0, n_fail = 0;

  localparam logic [31:0] ST_FULL  = 32'h0103_0000;
  localparam logic [31:0] ST_ALGN  = 32'h0100_0000;
  localparam logic [63:0] ST_EMPTY = 64'h8000_0000;

  always #2.5 clk = ~clk;

  tx_desc_dma u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof)
  );

  // memory and sink responder with random stalls, acting at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      mem_ack  = 1'b0;
      tx_ready = 1'b0;
    end else begin
      mem_ack = mem_req && ($urandom % 4 != 0);
      if (mem_ack && mem_we) mem[mem_addr[10:3]] = mem_wdata;
      if (mem_ack && !mem_we) begin
        mem_rdata = mem[mem_addr[10:3]];
        if (!first_seen) begin first_rd = mem_addr; first_seen = 1'b1; end
        if (mem_addr == watch_a) hits_a++;
        if (mem_addr == watch_b) hits_b++;
      end
      tx_ready = ($urandom % 4 != 0);
      if (tx_valid && tx_ready) begin
        cap_b.push_back(tx_data); cap_s.push_back(tx_sof); cap_e.push_back(tx_eof);
      end
    end
  end

  function automatic logic [7:0] mbyte(input logic [63:0] a);
    return 8'(mem[a[10:3]] >> {a[2:0], 3'b000});
  endfunction

  task automatic check(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic put_desc(input logic [63:0] base, input logic [63:0] nxt,
                          input logic [63:0] st, input logic [47:0] fa, input logic [15:0] len);
    mem[base[10:3]]     = nxt;
    mem[base[10:3] + 1] = st;
    mem[base[10:3] + 2] = {len, fa};
    mem[base[10:3] + 3] = '0;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic clear_run();
    cap_b.delete(); cap_s.delete(); cap_e.delete();
    exp_b.delete(); exp_s.delete(); exp_e.delete();
    first_seen = 1'b0; hits_a = 0; hits_b = 0;
  endtask

  task automatic add_seg(input logic [63:0] a, input int len);
    for (int i = 0; i < len; i++) begin
      exp_b.push_back(mbyte(a + 64'(i)));
      exp_s.push_back(i == 0);
      exp_e.push_back(i == len - 1);
    end
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 8) begin
      @(negedge clk);
      if (!mem_req && !tx_valid) q++; else q = 0;
    end
  endtask

  task automatic cmp_frame(input string rq);
    int bad = -1;
    check(cap_b.size() == exp_b.size(), rq, 64'(cap_b.size()), 64'(exp_b.size()));
    if (cap_b.size() == exp_b.size()) begin
      for (int i = 0; i < exp_b.size(); i++)
        if (bad < 0 && (cap_b[i] != exp_b[i] || cap_s[i] != exp_s[i] || cap_e[i] != exp_e[i])) bad = i;
      check(bad < 0, rq, (bad < 0) ? 64'd0 : {cap_s[bad], cap_e[bad], 8'h0, cap_b[bad]},
            (bad < 0) ? 64'd0 : {exp_s[bad], exp_e[bad], 8'h0, exp_b[bad]});
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [63:0] st;
    void'($urandom(32'd2024));
    watch_a = '1; watch_b = '1;
    for (int i = 0; i < 256; i++) mem[i] = (i >= 128) ? {$urandom, $urandom} : 64'd0;
    clear_run();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet after reset
    check(!mem_req && !tx_valid, "R1", {mem_req, tx_valid}, 64'd0);

    // R2 R4 R6: two-frame chain ending at an empty descriptor, pointer low bits set
    put_desc(64'h100, 64'h120, ST_FULL, 48'h400, 16'd5);
    put_desc(64'h120, 64'h140, ST_FULL, 48'h503, 16'd13);
    put_desc(64'h140, 64'h160, ST_EMPTY, 48'h600, 16'd3);
    put_desc(64'h160, 64'h000, ST_EMPTY, 48'h0, 16'd0);
    clear_run();
    add_seg(64'h400, 5); add_seg(64'h503, 13);
    reg_wr(8'h14, 32'h0); reg_wr(8'h10, 32'h11F); reg_wr(8'h00, 32'h1000);
    wait_idle();
    check(first_rd == 64'h100, "R2", first_rd, 64'h100);
    cmp_frame("R4");
    check(mem[8'h21] == (64'(ST_FULL) | ST_EMPTY), "R6", mem[8'h21], 64'(ST_FULL) | ST_EMPTY);
    check(mem[8'h25] == (64'(ST_FULL) | ST_EMPTY), "R6", mem[8'h25], 64'(ST_FULL) | ST_EMPTY);
    check(mem[8'h29] == ST_EMPTY, "R3", mem[8'h29], ST_EMPTY);

    // R3: pointer stayed on the empty descriptor; fill it and poll again
    mem[8'h29] = 64'(ST_FULL);
    clear_run(); add_seg(64'h600, 3);
    reg_wr(8'h00, 32'h1000);
    wait_idle();
    check(first_rd == 64'h140, "R3", first_rd, 64'h140);
    cmp_frame("R3");

    // R5: alignment bits clear, low address bits dropped
    put_desc(64'h180, 64'h1A0, ST_ALGN, 48'h605, 16'd6);
    put_desc(64'h1A0, 64'h000, ST_EMPTY, 48'h0, 16'd0);
    clear_run(); add_seg(64'h600, 6);
    reg_wr(8'h10, 32'h180); reg_wr(8'h00, 32'h1000);
    wait_idle();
    cmp_frame("R5");

    // R7: zero length and zero count complete with no output
    put_desc(64'h1C0, 64'h1E0, ST_FULL, 48'h400, 16'd0);
    put_desc(64'h1E0, 64'h0A0, 32'h0003_0000, 48'h400, 16'd4);
    put_desc(64'h0A0, 64'h000, ST_EMPTY, 48'h0, 16'd0);
    clear_run(); watch_a = 64'h0A8;
    reg_wr(8'h10, 32'h1C0); reg_wr(8'h00, 32'h1000);
    wait_idle();
    check(cap_b.size() == 0, "R7", 64'(cap_b.size()), 64'd0);
    check(mem[8'h39][31] && mem[8'h3D][31], "R7", {mem[8'h39][31], mem[8'h3D][31]}, 64'd3);
    check(hits_a == 1, "R7", 64'(hits_a), 64'd1);

    // R8 R9: poll and pointer write while busy
    put_desc(64'h020, 64'h040, ST_FULL, 48'h700, 16'd20);
    put_desc(64'h040, 64'h000, ST_EMPTY, 48'h0, 16'd0);
    clear_run(); add_seg(64'h700, 20);
    watch_a = 64'h048; watch_b = 64'h300;
    reg_wr(8'h10, 32'h020); reg_wr(8'h00, 32'h1000);
    while (!tx_valid) @(negedge clk);
    reg_wr(8'h00, 32'h1000); reg_wr(8'h10, 32'h300);
    wait_idle();
    cmp_frame("R8");
    check(hits_a == 2, "R8", 64'(hits_a), 64'd2);
    check(hits_b == 0, "R9", 64'(hits_b), 64'd0);

    // R2: high pointer half reaches the address port
    clear_run(); watch_a = '1; watch_b = '1;
    reg_wr(8'h14, 32'h1); reg_wr(8'h10, 32'h0A0); reg_wr(8'h00, 32'h1000);
    wait_idle();
    check(first_rd == 64'h1_0000_00A0, "R2", first_rd, 64'h1_0000_00A0);
    reg_wr(8'h14, 32'h0);

    // R4 R5 R10: random frames under random stalls
    for (int k = 0; k < 12; k++) begin
      logic [47:0] fa;
      int ln;
      logic any;
      fa  = 48'h400 + 48'($urandom % 32'h300);
      ln  = 1 + int'($urandom % 40);
      any = $urandom % 2 == 1;
      st  = any ? 64'(ST_FULL) : 64'(ST_ALGN);
      put_desc(64'h060, 64'h080, st, fa, 16'(ln));
      put_desc(64'h080, 64'h000, ST_EMPTY, 48'h0, 16'd0);
      clear_run();
      add_seg(any ? 64'(fa) : (64'(fa) & ~64'd7), ln);
      reg_wr(8'h10, 32'h060); reg_wr(8'h00, 32'h1000);
      wait_idle();
      cmp_frame("R10");
      check(mem[8'h0D] == (st | ST_EMPTY), "R6", mem[8'h0D], st | ST_EMPTY);
    end
    finish_up();
  end
endmodule